// File: doc/BRIEF.md
# Single-Cycle MIPS Subset Processor with Extended Decode

This block is a single-cycle processor for a small 32-bit MIPS integer subset. On every enabled clock it fetches one word from an internal instruction array, decodes it, reads two source registers, computes in the ALU, optionally reads or writes an internal data array, writes the result back and selects the next program counter. The base set covers register-register arithmetic and logic, word load, word store, branch-on-equal and the absolute jump. Four additions sit on top of it without changing any base instruction: add-immediate, branch-on-not-equal, jump-through-register and a load whose address is the sum of two registers.

Both memories are small internal arrays. They are filled through a load port while `run` is low. Once filled, `run` is raised and the program executes. Afterwards, registered read-back ports let the environment observe any register or data word. While `run` is low, the program counter and all architectural state hold.

Top module: `sc_mips_core`

## Requirements
- R1: A synchronous active-high reset sets the program counter to 0. While `run` is low, the program counter does not change and no register or data word is written by the core.
- R2: An instruction that is not a taken branch or jump advances the program counter by 4. The instruction word is fetched from word index `pc[IMEM_AW+1:2]`.
- R3: Opcode 0 with funct 6'h20 (add), 6'h22 (sub), 6'h24 (and), 6'h25 (or) or 6'h2A (signed set-less-than) writes the result of rs op rt to register rd. The rs field is bits 25:21, rt is 20:16, rd is 15:11 and funct is 5:0.
- R4: Opcode 6'h08 writes rs plus the sign-extended 16-bit immediate (bits 15:0) to rt.
- R5: Opcode 6'h23 loads, and opcode 6'h2B stores, the 32-bit word at byte address rs + sign-extended immediate. The load writes rt; the store writes rt's value. Data is addressed by byte-address bits `[DMEM_AW+1:2]`.
- R6: Opcode 6'h04 branches when rs equals rt, to PC+4 plus the sign-extended immediate shifted left by 2.
- R7: Opcode 6'h05 branches to the same target when rs differs from rt, and falls through when they are equal.
- R8: Opcode 0 with funct 6'h08 sets the next program counter to the value of rs and writes no register, even when the rd field is nonzero.
- R9: Opcode 0 with funct 6'h3F loads the data word at byte address rs + rt into register rd.
- R10: Opcode 6'h02 jumps to {PC+4[31:28], bits 25:0, 2'b00}.
- R11: Register 0 always reads as zero, and writes to it are discarded.
- R12: The register and data read-back ports return the addressed value on the clock edge after the address is presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Executes one instruction per clock when high |
| ld_imem_we | input | 1 | Writes `ld_data` into the instruction array |
| ld_imem_addr | input | IMEM_AW | Word index for an instruction load |
| ld_dmem_we | input | 1 | Writes `ld_data` into the data array |
| ld_dmem_addr | input | DMEM_AW | Word index for a data load |
| ld_data | input | 32 | Load-port data |
| dbg_reg_addr | input | log2(NREG) | Register read-back address |
| dbg_reg_data | output | 32 | Registered register read-back value |
| dbg_mem_addr | input | DMEM_AW | Data-word read-back index |
| dbg_mem_data | output | 32 | Registered data-word read-back value |
| pc_o | output | 32 | Current program counter |

## Verification
A single preloaded program drives every opcode and funct value. The operand pair 5 and -3 tells signed set-less-than apart from an unsigned compare, and separates and from or and add from sub. Each branch kind runs once taken and once not taken. In each taken case, a marker write that lands in a skipped slot shows whether the program counter redirected. The two register-register loads target one word just written by a store and one word preloaded through the load port, so they confirm that the address is rs + rt and not rs + immediate. The jump-register encodes a nonzero rd to show that its write is suppressed, and an add-immediate that targets register 0 checks that writes to register 0 are discarded.

// File: rtl/sc_pkg.sv
package sc_pkg;

  localparam int XLEN = 32;

  localparam logic [5:0] OP_RTYPE = 6'h00;
  localparam logic [5:0] OP_JUMP  = 6'h02;
  localparam logic [5:0] OP_BEQ   = 6'h04;
  localparam logic [5:0] OP_BNE   = 6'h05;
  localparam logic [5:0] OP_ADDI  = 6'h08;
  localparam logic [5:0] OP_LW    = 6'h23;
  localparam logic [5:0] OP_SW    = 6'h2B;

  localparam logic [5:0] FN_ADD   = 6'h20;
  localparam logic [5:0] FN_SUB   = 6'h22;
  localparam logic [5:0] FN_AND   = 6'h24;
  localparam logic [5:0] FN_OR    = 6'h25;
  localparam logic [5:0] FN_SLT   = 6'h2A;
  localparam logic [5:0] FN_JREG  = 6'h08;
  localparam logic [5:0] FN_LDRR  = 6'h3F;

  typedef enum logic [3:0] {
    ALU_AND = 4'b0000,
    ALU_OR  = 4'b0001,
    ALU_ADD = 4'b0010,
    ALU_SUB = 4'b0110,
    ALU_SLT = 4'b0111
  } alu_fn_e;

  // classic 10-bit main control word, fields in their conventional order
  typedef struct packed {
    logic       dst_rd;
    logic       jump;
    logic       branch;
    logic       mem_rd;
    logic       wb_mem;
    logic [1:0] alu_op;
    logic       mem_wr;
    logic       src_imm;
    logic       reg_wr;
  } ctrl_t;

  // additional decode outputs for the extensions
  typedef struct packed {
    logic branch_ne;
    logic jump_reg;
  } ctrl_ext_t;

endpackage

// File: rtl/sc_decode.sv
module sc_decode
  import sc_pkg::*;
(
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  output ctrl_t      ctl,
  output ctrl_ext_t  ext,
  output alu_fn_e    alu_fn
);

  always_comb begin
    ctl = '0;
    ext = '0;
    unique case (opcode)
      OP_RTYPE: begin
        ctl.dst_rd = 1'b1;
        ctl.alu_op = 2'b10;
        ctl.reg_wr = 1'b1;
        if (funct == FN_JREG) begin
          ctl.reg_wr   = 1'b0;
          ext.jump_reg = 1'b1;
        end
        if (funct == FN_LDRR) begin
          ctl.mem_rd = 1'b1;
          ctl.wb_mem = 1'b1;
        end
      end
      OP_LW: begin
        ctl.src_imm = 1'b1;
        ctl.mem_rd  = 1'b1;
        ctl.wb_mem  = 1'b1;
        ctl.reg_wr  = 1'b1;
      end
      OP_SW: begin
        ctl.src_imm = 1'b1;
        ctl.mem_wr  = 1'b1;
      end
      OP_BEQ: begin
        ctl.branch = 1'b1;
        ctl.alu_op = 2'b01;
      end
      OP_BNE: begin
        ctl.branch    = 1'b1;
        ctl.alu_op    = 2'b01;
        ext.branch_ne = 1'b1;
      end
      OP_ADDI: begin
        ctl.src_imm = 1'b1;
        ctl.reg_wr  = 1'b1;
      end
      OP_JUMP: ctl.jump = 1'b1;
      default: ;
    endcase
  end

  always_comb begin
    alu_fn = ALU_ADD;
    unique case (ctl.alu_op)
      2'b01: alu_fn = ALU_SUB;
      2'b10: begin
        unique case (funct)
          FN_SUB:  alu_fn = ALU_SUB;
          FN_AND:  alu_fn = ALU_AND;
          FN_OR:   alu_fn = ALU_OR;
          FN_SLT:  alu_fn = ALU_SLT;
          default: alu_fn = ALU_ADD;
        endcase
      end
      default: alu_fn = ALU_ADD;
    endcase
  end

endmodule

// File: rtl/sc_alu.sv
module sc_alu
  import sc_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  alu_fn_e      fn,
  output logic [W-1:0] y,
  output logic         zero
);

  always_comb begin
    unique case (fn)
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      ALU_SUB: y = a - b;
      ALU_SLT: y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
      default: y = a + b;
    endcase
  end

  assign zero = (y == '0);

endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
  parameter int W    = 32,
  parameter int NREG = 32,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] ra_a,
  input  logic [AW-1:0] ra_b,
  input  logic [AW-1:0] ra_dbg,
  output logic [W-1:0]  rd_a,
  output logic [W-1:0]  rd_b,
  output logic [W-1:0]  rd_dbg,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [W-1:0]  wd
);

  logic [W-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (we && wa != '0) begin
      regs[wa] <= wd;
    end
  end

  assign rd_a   = (ra_a   == '0) ? '0 : regs[ra_a];
  assign rd_b   = (ra_b   == '0) ? '0 : regs[ra_b];
  assign rd_dbg = (ra_dbg == '0) ? '0 : regs[ra_dbg];

endmodule

// File: rtl/sc_mips_core.sv
module sc_mips_core
  import sc_pkg::*;
#(
  parameter int IMEM_AW = 6,
  parameter int DMEM_AW = 6,
  parameter int NREG    = 32,
  localparam int RAW    = $clog2(NREG)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               run,
  input  logic               ld_imem_we,
  input  logic [IMEM_AW-1:0] ld_imem_addr,
  input  logic               ld_dmem_we,
  input  logic [DMEM_AW-1:0] ld_dmem_addr,
  input  logic [XLEN-1:0]    ld_data,
  input  logic [RAW-1:0]     dbg_reg_addr,
  output logic [XLEN-1:0]    dbg_reg_data,
  input  logic [DMEM_AW-1:0] dbg_mem_addr,
  output logic [XLEN-1:0]    dbg_mem_data,
  output logic [XLEN-1:0]    pc_o
);

  localparam int IDEPTH = 1 << IMEM_AW;
  localparam int DDEPTH = 1 << DMEM_AW;

  logic [XLEN-1:0] imem [IDEPTH];
  logic [XLEN-1:0] dmem [DDEPTH];

  logic [XLEN-1:0] pc;
  logic [XLEN-1:0] instr;
  logic [5:0]      opcode, funct;
  logic [RAW-1:0]  f_rs, f_rt, f_rd;
  logic [XLEN-1:0] imm_sx;

  ctrl_t     ctl;
  ctrl_ext_t ext;
  alu_fn_e   alu_fn;

  logic [XLEN-1:0] rs_val, rt_val, rf_dbg;
  logic [XLEN-1:0] alu_b, alu_y, mem_q, wb_val;
  logic            alu_zero;
  logic [RAW-1:0]  wr_addr;
  logic [DMEM_AW-1:0] d_idx;

  logic [XLEN-1:0] pc_plus4, br_target, j_target, pc_next;
  logic            br_take;

  // fetch and field split
  assign instr  = imem[pc[IMEM_AW+1:2]];
  assign opcode = instr[31:26];
  assign funct  = instr[5:0];
  assign f_rs   = instr[21 +: RAW];
  assign f_rt   = instr[16 +: RAW];
  assign f_rd   = instr[11 +: RAW];
  assign imm_sx = {{(XLEN-16){instr[15]}}, instr[15:0]};

  sc_decode u_dec (
    .opcode (opcode),
    .funct  (funct),
    .ctl    (ctl),
    .ext    (ext),
    .alu_fn (alu_fn)
  );

  sc_regfile #(.W(XLEN), .NREG(NREG)) u_rf (
    .clk    (clk),
    .rst    (rst),
    .ra_a   (f_rs),
    .ra_b   (f_rt),
    .ra_dbg (dbg_reg_addr),
    .rd_a   (rs_val),
    .rd_b   (rt_val),
    .rd_dbg (rf_dbg),
    .we     (run && ctl.reg_wr),
    .wa     (wr_addr),
    .wd     (wb_val)
  );

  assign alu_b = ctl.src_imm ? imm_sx : rt_val;

  sc_alu #(.W(XLEN)) u_alu (
    .a    (rs_val),
    .b    (alu_b),
    .fn   (alu_fn),
    .y    (alu_y),
    .zero (alu_zero)
  );

  // data memory: asynchronous read, one shared write port
  assign d_idx  = alu_y[DMEM_AW+1:2];
  assign mem_q  = dmem[d_idx];
  assign wb_val = ctl.wb_mem ? mem_q : alu_y;
  assign wr_addr = ctl.dst_rd ? f_rd : f_rt;

  always_ff @(posedge clk) begin
    if (run && ctl.mem_wr)
      dmem[d_idx] <= rt_val;
    else if (ld_dmem_we)
      dmem[ld_dmem_addr] <= ld_data;
  end

  always_ff @(posedge clk) begin
    if (ld_imem_we) imem[ld_imem_addr] <= ld_data;
  end

  // next-PC selection
  assign pc_plus4  = pc + 32'd4;
  assign br_target = pc_plus4 + {imm_sx[XLEN-3:0], 2'b00};
  assign j_target  = {pc_plus4[31:28], instr[25:0], 2'b00};
  assign br_take   = ctl.branch && (alu_zero ^ ext.branch_ne);

  always_comb begin
    if (ext.jump_reg)  pc_next = rs_val;
    else if (ctl.jump) pc_next = j_target;
    else if (br_take)  pc_next = br_target;
    else               pc_next = pc_plus4;
  end

  always_ff @(posedge clk) begin
    if (rst)      pc <= '0;
    else if (run) pc <= pc_next;
  end

  assign pc_o = pc;

  // registered read-back
  always_ff @(posedge clk) begin
    if (rst) begin
      dbg_reg_data <= '0;
      dbg_mem_data <= '0;
    end else begin
      dbg_reg_data <= rf_dbg;
      dbg_mem_data <= dmem[dbg_mem_addr];
    end
  end

endmodule

// File: rtl/sc_mips_core_chk.sv
module sc_mips_core_chk #(
  parameter int RAW = 5
) (
  input logic           clk,
  input logic           rst,
  input logic           run,
  input logic [31:0]    pc_o,
  input logic [31:0]    instr,
  input logic [31:0]    rs_val,
  input logic [31:0]    rt_val,
  input logic [RAW-1:0] dbg_reg_addr,
  input logic [31:0]    dbg_reg_data
);

  logic [5:0]  op;
  logic        is_jr, plain;
  logic [31:0] tgt;

  assign op    = instr[31:26];
  assign is_jr = (op == 6'h00) && (instr[5:0] == 6'h08);
  assign plain = !is_jr && op != 6'h04 && op != 6'h05 && op != 6'h02;
  assign tgt   = pc_o + 32'd4 + {{14{instr[15]}}, instr[15:0], 2'b00};

  assert_pc_reset_R1: assert property (@(posedge clk) rst |=> pc_o == 32'd0);

  assert_pc_hold_R1: assert property (@(posedge clk) disable iff (rst)
    !run |=> $stable(pc_o));

  assert_pc_step_R2: assert property (@(posedge clk) disable iff (rst)
    run && plain |=> pc_o == $past(pc_o) + 32'd4);

  assert_beq_taken_R6: assert property (@(posedge clk) disable iff (rst)
    run && op == 6'h04 && rs_val == rt_val |=> pc_o == $past(tgt));

  assert_bne_taken_R7: assert property (@(posedge clk) disable iff (rst)
    run && op == 6'h05 && rs_val != rt_val |=> pc_o == $past(tgt));

  assert_bne_fall_R7: assert property (@(posedge clk) disable iff (rst)
    run && op == 6'h05 && rs_val == rt_val |=> pc_o == $past(pc_o) + 32'd4);

  assert_jreg_R8: assert property (@(posedge clk) disable iff (rst)
    run && is_jr |=> pc_o == $past(rs_val));

  assert_zero_reg_R11: assert property (@(posedge clk) disable iff (rst)
    dbg_reg_addr == '0 |=> dbg_reg_data == 32'd0);

endmodule

bind sc_mips_core sc_mips_core_chk #(.RAW(RAW)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .run          (run),
  .pc_o         (pc_o),
  .instr        (instr),
  .rs_val       (rs_val),
  .rt_val       (rt_val),
  .dbg_reg_addr (dbg_reg_addr),
  .dbg_reg_data (dbg_reg_data)
);

// File: tb/sc_mips_core_bench.sv
module sc_mips_core_bench;

  localparam int IMEM_AW = 6;
  localparam int DMEM_AW = 6;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               run = 1'b0;
  logic               ld_imem_we = 1'b0;
  logic [IMEM_AW-1:0] ld_imem_addr = '0;
  logic               ld_dmem_we = 1'b0;
  logic [DMEM_AW-1:0] ld_dmem_addr = '0;
  logic [31:0]        ld_data = '0;
  logic [4:0]         dbg_reg_addr = '0;
  logic [31:0]        dbg_reg_data;
  logic [DMEM_AW-1:0] dbg_mem_addr = '0;
  logic [31:0]        dbg_mem_data;
  logic [31:0]        pc_o;

  always #10 clk = ~clk;

  sc_mips_core #(.IMEM_AW(IMEM_AW), .DMEM_AW(DMEM_AW)) u_sc_mips_core (
    .clk, .rst, .run, .ld_imem_we, .ld_imem_addr, .ld_dmem_we, .ld_dmem_addr,
    .ld_data, .dbg_reg_addr, .dbg_reg_data, .dbg_mem_addr, .dbg_mem_data, .pc_o
  );

  typedef struct {
    bit          is_mem;
    int          addr;
    logic [31:0] exp;
    string       req;
  } exp_t;

  exp_t exp_q[$];
  int   n_checks = 0;
  int   n_errors = 0;
  bit   mon_busy = 1'b0;

  function automatic logic [31:0] rtype(int rs, int rt, int rd, logic [5:0] fn);
    return {6'h00, rs[4:0], rt[4:0], rd[4:0], 5'd0, fn};
  endfunction

  function automatic logic [31:0] itype(logic [5:0] op, int rs, int rt, logic [15:0] imm);
    return {op, rs[4:0], rt[4:0], imm};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  endtask

  task automatic put_instr(int idx, logic [31:0] w);
    @(negedge clk);
    ld_imem_we = 1'b1; ld_imem_addr = idx[IMEM_AW-1:0]; ld_data = w;
    @(negedge clk);
    ld_imem_we = 1'b0;
  endtask

  task automatic put_data(int idx, logic [31:0] w);
    @(negedge clk);
    ld_dmem_we = 1'b1; ld_dmem_addr = idx[DMEM_AW-1:0]; ld_data = w;
    @(negedge clk);
    ld_dmem_we = 1'b0;
  endtask

  task automatic expect_reg(int r, logic [31:0] v, string req);
    exp_q.push_back('{1'b0, r, v, req});
  endtask

  task automatic expect_mem(int w, logic [31:0] v, string req);
    exp_q.push_back('{1'b1, w, v, req});
  endtask

  // monitor: drains the scoreboard through the registered read-back ports
  initial begin
    forever begin
      exp_t it;
      wait (exp_q.size() > 0);
      mon_busy = 1'b1;
      it = exp_q.pop_front();
      @(negedge clk);
      if (it.is_mem) dbg_mem_addr = it.addr[DMEM_AW-1:0];
      else           dbg_reg_addr = it.addr[4:0];
      @(negedge clk);
      check(it.req, it.is_mem ? dbg_mem_data : dbg_reg_data, it.exp);
      mon_busy = 1'b0;
    end
  end

  initial begin
    #(20 * 100000);
    n_errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  localparam logic [31:0] A = 32'd5;
  localparam logic [31:0] B = 32'hFFFF_FFFD; // -3
  localparam logic [31:0] PRELOAD = 32'hCAFE_F00D;

  initial begin
    // program
    put_instr(0,  itype(6'h08, 0, 1, 16'd5));
    put_instr(1,  itype(6'h08, 0, 2, 16'hFFFD));
    put_instr(2,  rtype(1, 2, 3, 6'h20));
    put_instr(3,  rtype(1, 2, 4, 6'h22));
    put_instr(4,  rtype(1, 2, 5, 6'h24));
    put_instr(5,  rtype(1, 2, 6, 6'h25));
    put_instr(6,  rtype(2, 1, 7, 6'h2A));
    put_instr(7,  rtype(1, 2, 8, 6'h2A));
    put_instr(8,  itype(6'h08, 0, 9, 16'd8));
    put_instr(9,  itype(6'h2B, 9, 4, 16'd4));
    put_instr(10, itype(6'h23, 9, 10, 16'd4));
    put_instr(11, itype(6'h08, 0, 11, 16'd4));
    put_instr(12, rtype(9, 11, 12, 6'h3F));
    put_instr(13, rtype(9, 12, 13, 6'h3F));
    put_instr(14, itype(6'h08, 0, 0, 16'd7));
    put_instr(15, itype(6'h04, 1, 2, 16'd1));
    put_instr(16, itype(6'h08, 0, 14, 16'd1));
    put_instr(17, itype(6'h04, 1, 1, 16'd1));
    put_instr(18, itype(6'h08, 0, 15, 16'd99));
    put_instr(19, itype(6'h05, 1, 1, 16'd1));
    put_instr(20, itype(6'h08, 0, 16, 16'd2));
    put_instr(21, itype(6'h05, 1, 2, 16'd1));
    put_instr(22, itype(6'h08, 0, 17, 16'd99));
    put_instr(23, itype(6'h08, 0, 18, 16'd104));
    put_instr(24, rtype(18, 0, 19, 6'h08));
    put_instr(25, itype(6'h08, 0, 21, 16'd99));
    put_instr(26, {6'h02, 26'd28});
    put_instr(27, itype(6'h08, 0, 22, 16'd99));
    put_instr(28, itype(6'h08, 0, 23, 16'd7));
    put_instr(29, itype(6'h04, 0, 0, 16'hFFFF));
    put_data(4, PRELOAD);

    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 pc after reset", pc_o, 32'd0);
    repeat (3) @(negedge clk);
    check("R1 pc holds while idle", pc_o, 32'd0);

    run = 1'b1;
    @(negedge clk);
    check("R2 pc after first step", pc_o, 32'd4);
    repeat (79) @(negedge clk);
    run = 1'b0;
    check("R6 pc parked on self-branch", pc_o, 32'd29 * 4);
    repeat (3) @(negedge clk);
    check("R1 pc holds after stop", pc_o, 32'd29 * 4);

    expect_reg(1,  A,                         "R4 addi positive");
    expect_reg(2,  B,                         "R4 addi sign-extended");
    expect_reg(3,  A + B,                     "R3 add");
    expect_reg(4,  A - B,                     "R3 sub");
    expect_reg(5,  A & B,                     "R3 and");
    expect_reg(6,  A | B,                     "R3 or");
    expect_reg(7,  32'd1,                     "R3 slt signed true");
    expect_reg(8,  32'd0,                     "R3 slt signed false");
    expect_mem(3,  A - B,                     "R5 store word");
    expect_reg(10, A - B,                     "R5 load word");
    expect_reg(12, A - B,                     "R9 reg-reg load of stored word");
    expect_reg(13, PRELOAD,                   "R9 reg-reg load of preloaded word");
    expect_reg(0,  32'd0,                     "R11 register zero");
    expect_reg(14, 32'd1,                     "R6 beq fall-through");
    expect_reg(15, 32'd0,                     "R6 beq taken skips");
    expect_reg(16, 32'd2,                     "R7 bne fall-through");
    expect_reg(17, 32'd0,                     "R7 bne taken skips");
    expect_reg(19, 32'd0,                     "R8 jr writes no register");
    expect_reg(21, 32'd0,                     "R8 jr skips");
    expect_reg(22, 32'd0,                     "R10 jump skips");
    expect_reg(23, 32'd7,                     "R10 jump target executes");
    expect_mem(4,  PRELOAD,                   "R12 data read-back");

    wait (exp_q.size() == 0 && !mon_busy);
    @(negedge clk);
    finish_run();
  end

endmodule